// File: doc/BRIEF.md
# Protected Data Path with Fault Injection

This block carries a data word through three registered stages: an encoder that builds an error-correcting codeword, a fault stage that can corrupt that codeword on command, and a decoder that computes the syndrome, repairs what it can and raises status flags. A build-time switch selects between a plain single-error-correcting Hamming code and the extended form. The extended form appends one overall parity bit and also detects double errors. With the switch set, a data width of 8 gives a 13-bit codeword, 11 gives 16 and 12 gives 18. Without the switch those widths give 12, 15 and 17 bits.

The fault stage lets a test routine show that the protection works inside the host design. It can hold one codeword bit at 0, hold one bit at 1, or invert two bits. Each bit is chosen by a 0-based index, where index i stands for codeword position i+1. Check bits sit at positions 1, 2, 4, 8 and 16, and in extended mode the overall parity bit is at index N-1. The fault controls travel with the data word they are meant to corrupt. A valid bit moves alongside the word, so one word can enter on every cycle.

Top module: `ecc_guard`

## Requirements
- R1: A word presented with valid_in high on clock edge t appears on data_out with valid_out high after edge t+2, so it is visible three sampled edges later. Back-to-back words keep their order and one word leaves per cycle.
- R2: With fault_en low, data_out equals the input word and both flags are 0.
- R3: fault_kind encodes the fault as 0 = hold bit fault_pos_a at 0, 1 = hold it at 1, 2 = invert bits fault_pos_a and fault_pos_b, 3 = no fault. Code 3 leaves the word clean even when fault_en is high.
- R4: Any single effective bit error is corrected. This covers a data bit, a check bit, and, in extended mode, the overall parity bit. data_out equals the input word, sec_flag is 1 and ded_flag is 0.
- R5: A hold fault on a bit that already has the forced value changes nothing, and both flags stay 0.
- R6: In extended mode, inverting two distinct in-range bits sets ded_flag and clears sec_flag. data_out then carries the data bits of the corrupted codeword with no bit altered by the decoder.
- R7: A two-bit inversion with both indices equal cancels itself, so the output is clean and the flags are 0.
- R8: A fault index at or beyond the codeword length has no effect.
- R9: sec_flag and ded_flag are never high together, and both are 0 whenever valid_out is 0.
- R10: The active-high synchronous reset clears valid_out and both flags on the next edge.
- R11: In plain Hamming mode (SECDED=0) no overall parity bit exists. A nonzero syndrome within the codeword length is corrected and sets sec_flag. A syndrome beyond the length sets ded_flag and the data passes uncorrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input word valid |
| data_in | input | DATA_W | Data word to protect |
| fault_en | input | 1 | Enables the fault stage for this word |
| fault_kind | input | 2 | Fault type (R3 encoding) |
| fault_pos_a | input | POS_W | First codeword bit index |
| fault_pos_b | input | POS_W | Second index, used by the two-bit inversion |
| valid_out | output | 1 | Output word valid |
| data_out | output | DATA_W | Decoded and repaired data |
| sec_flag | output | 1 | A single error was corrected |
| ded_flag | output | 1 | An uncorrectable error was detected |

## Verification
The bench sweeps hold faults over every codeword index, including the overall parity bit. A decoder with a wrong syndrome-to-position mapping would flip the wrong bit, and one that mishandles a parity-only error would damage good data. Hold faults on bits that already hold the forced value must give a clean result; a design that treated every injection as an error would raise sec_flag there. Two-bit inversions go to both a Hamming and an extended instance: the extended one must flag without touching the data, and the plain one must miscorrect exactly where its syndrome lands or report an out-of-range syndrome. Equal and out-of-range indices, a reset in the middle of a stream, and random traffic with gaps catch masks that leak and valid bits that drift out of step with the data.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    FLT_LOW   = 2'd0,
    FLT_HIGH  = 2'd1,
    FLT_PAIR  = 2'd2,
    FLT_NONE  = 2'd3
  } fault_kind_e;

  // Smallest number of check bits p with 2**p >= dw + p + 1
  function automatic int chk_bits(input int dw);
    int p;
    p = 1;
    for (int i = 0; i < 8; i++)
      if ((1 << p) < dw + p + 1) p = p + 1;
    return p;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  parameter int CHK_W  = 4,
  parameter int HAM_N  = 12,
  parameter int CW_N   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [CW_N-1:0]   cw_o
);

  logic [HAM_N-1:0] spread;
  logic [HAM_N-1:0] ham;
  logic [CW_N-1:0]  full;

  // Place data bits on the non-power-of-two positions, lowest first
  function automatic logic [HAM_N-1:0] spread_f(input logic [DATA_W-1:0] d);
    logic [HAM_N-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int pos = 1; pos <= HAM_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        w[pos-1] = d[k];
        k = k + 1;
      end
    end
    return w;
  endfunction

  // Positions whose index has bit j set
  function automatic logic [HAM_N-1:0] cover_f(input int j);
    logic [HAM_N-1:0] m;
    for (int pos = 1; pos <= HAM_N; pos++)
      m[pos-1] = ((pos >> j) & 1) == 1;
    return m;
  endfunction

  always_comb begin
    spread = spread_f(data_i);
    ham    = spread;
    for (int j = 0; j < CHK_W; j++)
      ham[(1 << j) - 1] = ^(spread & cover_f(j));
  end

  generate
    if (SECDED) begin : g_ext
      assign full = {^ham, ham};
    end else begin : g_plain
      assign full = ham;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      cw_o  <= '0;
    end else begin
      vld_o <= vld_i;
      cw_o  <= full;
    end
  end

endmodule

// File: rtl/ecc_injector.sv
module ecc_injector #(
  parameter int CW_N  = 13,
  parameter int POS_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld_i,
  input  logic [CW_N-1:0]     cw_i,
  input  logic                en_i,
  input  ecc_pkg::fault_kind_e kind_i,
  input  logic [POS_W-1:0]    pos_a_i,
  input  logic [POS_W-1:0]    pos_b_i,
  output logic                vld_o,
  output logic [CW_N-1:0]     cw_o
);

  logic [CW_N-1:0] mask_a;
  logic [CW_N-1:0] mask_b;
  logic [CW_N-1:0] hit;

  // One-hot masks; an index at or past CW_N selects nothing
  generate
    for (genvar i = 0; i < CW_N; i++) begin : g_mask
      assign mask_a[i] = (pos_a_i == POS_W'(i));
      assign mask_b[i] = (pos_b_i == POS_W'(i));
    end
  endgenerate

  always_comb begin
    hit = cw_i;
    if (en_i) begin
      unique case (kind_i)
        ecc_pkg::FLT_LOW:  hit = cw_i & ~mask_a;
        ecc_pkg::FLT_HIGH: hit = cw_i | mask_a;
        ecc_pkg::FLT_PAIR: hit = cw_i ^ mask_a ^ mask_b;
        default:           hit = cw_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      cw_o  <= '0;
    end else begin
      vld_o <= vld_i;
      cw_o  <= hit;
    end
  end

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder #(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  parameter int CHK_W  = 4,
  parameter int HAM_N  = 12,
  parameter int CW_N   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [CW_N-1:0]   cw_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);

  logic [CHK_W-1:0] syn;
  logic             par_bad;
  logic             in_range;
  logic             do_fix;
  logic             sec_c;
  logic             ded_c;
  logic [HAM_N-1:0] fix;
  logic [HAM_N-1:0] repaired;

  function automatic logic [DATA_W-1:0] gather_f(input logic [HAM_N-1:0] w);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 1; pos <= HAM_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        d[k] = w[pos-1];
        k = k + 1;
      end
    end
    return d;
  endfunction

  always_comb begin
    syn = '0;
    for (int pos = 1; pos <= HAM_N; pos++)
      if (cw_i[pos-1]) syn = syn ^ CHK_W'(pos);
    par_bad  = ^cw_i;
    in_range = (syn != '0) && (int'(syn) <= HAM_N);
  end

  // Classify: overall parity decides odd or even error count in extended mode
  always_comb begin
    sec_c  = 1'b0;
    ded_c  = 1'b0;
    do_fix = 1'b0;
    if (SECDED) begin
      if (!par_bad) begin
        ded_c = (syn != '0);
      end else if (syn == '0) begin
        sec_c = 1'b1;
      end else if (in_range) begin
        sec_c  = 1'b1;
        do_fix = 1'b1;
      end else begin
        ded_c = 1'b1;
      end
    end else if (syn != '0) begin
      if (in_range) begin
        sec_c  = 1'b1;
        do_fix = 1'b1;
      end else begin
        ded_c = 1'b1;
      end
    end
  end

  always_comb begin
    for (int pos = 1; pos <= HAM_N; pos++)
      fix[pos-1] = do_fix && (syn == CHK_W'(pos));
    repaired = cw_i[HAM_N-1:0] ^ fix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      sec_o  <= 1'b0;
      ded_o  <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      data_o <= gather_f(repaired);
      sec_o  <= vld_i && sec_c;
      ded_o  <= vld_i && ded_c;
    end
  end

endmodule

// File: rtl/ecc_guard.sv
module ecc_guard #(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              fault_en,
  input  logic [1:0]        fault_kind,
  input  logic [POS_W-1:0]  fault_pos_a,
  input  logic [POS_W-1:0]  fault_pos_b,
  output logic              valid_out,
  output logic [DATA_W-1:0] data_out,
  output logic              sec_flag,
  output logic              ded_flag
);

  localparam int CHK_W = ecc_pkg::chk_bits(DATA_W);
  localparam int HAM_N = DATA_W + CHK_W;
  localparam int CW_N  = HAM_N + (SECDED ? 1 : 0);

  logic                 enc_vld;
  logic [CW_N-1:0]      enc_cw;
  logic                 inj_vld;
  logic [CW_N-1:0]      inj_cw;
  logic                 f_en_q;
  ecc_pkg::fault_kind_e f_kind_q;
  logic [POS_W-1:0]     f_pos_a_q;
  logic [POS_W-1:0]     f_pos_b_q;

  // Fault controls ride in stage 1 next to the word they apply to
  always_ff @(posedge clk) begin
    if (rst) begin
      f_en_q    <= 1'b0;
      f_kind_q  <= ecc_pkg::FLT_NONE;
      f_pos_a_q <= '0;
      f_pos_b_q <= '0;
    end else begin
      f_en_q    <= fault_en;
      f_kind_q  <= ecc_pkg::fault_kind_e'(fault_kind);
      f_pos_a_q <= fault_pos_a;
      f_pos_b_q <= fault_pos_b;
    end
  end

  ecc_encoder #(
    .DATA_W(DATA_W), .SECDED(SECDED), .CHK_W(CHK_W), .HAM_N(HAM_N), .CW_N(CW_N)
  ) u_enc (
    .clk(clk), .rst(rst), .vld_i(valid_in), .data_i(data_in),
    .vld_o(enc_vld), .cw_o(enc_cw)
  );

  ecc_injector #(
    .CW_N(CW_N), .POS_W(POS_W)
  ) u_inj (
    .clk(clk), .rst(rst), .vld_i(enc_vld), .cw_i(enc_cw),
    .en_i(f_en_q), .kind_i(f_kind_q), .pos_a_i(f_pos_a_q), .pos_b_i(f_pos_b_q),
    .vld_o(inj_vld), .cw_o(inj_cw)
  );

  ecc_decoder #(
    .DATA_W(DATA_W), .SECDED(SECDED), .CHK_W(CHK_W), .HAM_N(HAM_N), .CW_N(CW_N)
  ) u_dec (
    .clk(clk), .rst(rst), .vld_i(inj_vld), .cw_i(inj_cw),
    .vld_o(valid_out), .data_o(data_out), .sec_o(sec_flag), .ded_o(ded_flag)
  );

endmodule

// File: rtl/ecc_guard_chk.sv
module ecc_guard_chk #(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  parameter int POS_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_in,
  input logic [DATA_W-1:0] data_in,
  input logic              fault_en,
  input logic [1:0]        fault_kind,
  input logic [POS_W-1:0]  fault_pos_a,
  input logic [POS_W-1:0]  fault_pos_b,
  input logic              valid_out,
  input logic [DATA_W-1:0] data_out,
  input logic              sec_flag,
  input logic              ded_flag
);

  localparam int CW_N = DATA_W + ecc_pkg::chk_bits(DATA_W) + (SECDED ? 1 : 0);

  logic [1:0] since_rst;
  logic       warm;
  logic       pair_hit;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign warm     = (since_rst == 2'd3);
  assign pair_hit = fault_en && (fault_kind == 2'd2) && (fault_pos_a != fault_pos_b)
                    && (int'(fault_pos_a) < CW_N) && (int'(fault_pos_b) < CW_N);

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    warm |-> (valid_out == $past(valid_in, 3)));

  p_clean_r2: assert property (@(posedge clk) disable iff (rst)
    (warm && valid_out && !$past(fault_en, 3)) |->
      (data_out == $past(data_in, 3) && !sec_flag && !ded_flag));

  p_pair_r6: assert property (@(posedge clk) disable iff (rst)
    (warm && SECDED && valid_out && $past(pair_hit, 3)) |-> (ded_flag && !sec_flag));

  p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
    (warm && valid_out && $past(fault_en && fault_kind == 2'd2 && fault_pos_a == fault_pos_b, 3))
      |-> (data_out == $past(data_in, 3) && !sec_flag && !ded_flag));

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(sec_flag && ded_flag));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_out |-> (!sec_flag && !ded_flag));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!valid_out && !sec_flag && !ded_flag));

endmodule

bind ecc_guard ecc_guard_chk #(.DATA_W(DATA_W), .SECDED(SECDED), .POS_W(POS_W)) u_chk (.*);

// File: tb/tb_ecc_guard.sv
module tb_ecc_guard;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int PW = 5;
  localparam int HN = 12;     // data + check bits
  localparam int NS = 13;     // extended codeword length
  localparam int NP = 12;     // plain codeword length

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_in = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          fault_en = 1'b0;
  logic [1:0]    fault_kind = 2'd3;
  logic [PW-1:0] pos_a = '0;
  logic [PW-1:0] pos_b = '0;

  logic          vo_s, sec_s, ded_s;
  logic [DW-1:0] do_s;
  logic          vo_h, sec_h, ded_h;
  logic [DW-1:0] do_h;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_guard #(.DATA_W(DW), .SECDED(1'b1), .POS_W(PW)) dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .data_in(data_in),
    .fault_en(fault_en), .fault_kind(fault_kind), .fault_pos_a(pos_a), .fault_pos_b(pos_b),
    .valid_out(vo_s), .data_out(do_s), .sec_flag(sec_s), .ded_flag(ded_s));

  ecc_guard #(.DATA_W(DW), .SECDED(1'b0), .POS_W(PW)) dut_ham (
    .clk(clk), .rst(rst), .valid_in(valid_in), .data_in(data_in),
    .fault_en(fault_en), .fault_kind(fault_kind), .fault_pos_a(pos_a), .fault_pos_b(pos_b),
    .valid_out(vo_h), .data_out(do_h), .sec_flag(sec_h), .ded_flag(ded_h));

  // Expected-value pipeline, index 2 is the oldest
  bit            hv[3];
  logic [DW-1:0] hd_s[3], hd_h[3];
  bit            hsec_s[3], hded_s[3], hsec_h[3], hded_h[3];
  int            htag_s[3], htag_h[3];

  function automatic string tname(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [31:0] enc(input logic [DW-1:0] d, input bit ext);
    logic [31:0] cw;
    int k;
    bit b;
    cw = '0;
    k = 0;
    for (int pos = 1; pos <= HN; pos++)
      if ((pos & (pos - 1)) != 0) begin cw[pos-1] = d[k]; k++; end
    for (int j = 0; (1 << j) <= HN; j++) begin
      b = 0;
      for (int pos = 1; pos <= HN; pos++)
        if (((pos >> j) & 1) == 1 && pos != (1 << j)) b = b ^ cw[pos-1];
      cw[(1 << j) - 1] = b;
    end
    if (ext) cw[HN] = ^cw[HN-1:0];
    return cw;
  endfunction

  function automatic logic [DW-1:0] pull(input logic [31:0] cw);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 1; pos <= HN; pos++)
      if ((pos & (pos - 1)) != 0) begin d[k] = cw[pos-1]; k++; end
    return d;
  endfunction

  function automatic logic [31:0] inj(input logic [31:0] cw, input bit en, input logic [1:0] k,
                                      input int a, input int b, input int n);
    logic [31:0] r;
    r = cw;
    if (en) begin
      if (k == 2'd0 && a < n) r[a] = 1'b0;
      if (k == 2'd1 && a < n) r[a] = 1'b1;
      if (k == 2'd2) begin
        if (a < n) r[a] = ~r[a];
        if (b < n) r[b] = ~r[b];
      end
    end
    return r;
  endfunction

  task automatic model(input logic [DW-1:0] d, input bit ext, input bit en, input logic [1:0] k,
                       input int a, input int b, input int n, input int tag_over,
                       output logic [DW-1:0] ed, output bit es, output bit ee, output int tag);
    logic [31:0] clean, bad, diff;
    int c, syn;
    clean = enc(d, ext);
    bad   = inj(clean, en, k, a, b, n);
    diff  = bad ^ clean;
    c     = $countones(diff);
    ed = d; es = 0; ee = 0;
    if (c == 1) es = 1;
    if (c == 2) begin
      if (ext) begin
        ed = pull(bad); ee = 1;
      end else begin
        syn = 0;
        for (int i = 0; i < n; i++) if (diff[i]) syn = syn ^ (i + 1);
        if (syn <= HN) begin
          ed = pull(bad ^ (32'd1 << (syn - 1))); es = 1;
        end else begin
          ed = pull(bad); ee = 1;
        end
      end
    end
    if (!en) tag = 2;
    else if (k == 2'd3) tag = 3;
    else if (c == 0) tag = (a >= n) ? 8 : ((k == 2'd2) ? 7 : 5);
    else if (c == 1) tag = 4;
    else tag = ext ? 6 : 11;
    if (tag_over != 0) tag = tag_over;
  endtask

  task automatic check_out();
    checks++;
    if (hv[2]) begin
      if (!(vo_s === 1'b1 && do_s === hd_s[2] && sec_s === hsec_s[2] && ded_s === hded_s[2])) begin
        errors++;
        $display("FAIL %s ext: got v=%b d=%h sec=%b ded=%b exp v=1 d=%h sec=%b ded=%b",
                 tname(htag_s[2]), vo_s, do_s, sec_s, ded_s, hd_s[2], hsec_s[2], hded_s[2]);
      end
      checks++;
      if (!(vo_h === 1'b1 && do_h === hd_h[2] && sec_h === hsec_h[2] && ded_h === hded_h[2])) begin
        errors++;
        $display("FAIL %s plain: got v=%b d=%h sec=%b ded=%b exp v=1 d=%h sec=%b ded=%b",
                 tname(htag_h[2]), vo_h, do_h, sec_h, ded_h, hd_h[2], hsec_h[2], hded_h[2]);
      end
    end else begin
      // R1: valid only three edges after a valid input; R9: flags idle
      if (!(vo_s === 1'b0 && vo_h === 1'b0)) begin
        errors++;
        $display("FAIL R1: got valid_out=%b/%b exp 0/0", vo_s, vo_h);
      end
      checks++;
      if (!(sec_s === 1'b0 && ded_s === 1'b0 && sec_h === 1'b0 && ded_h === 1'b0)) begin
        errors++;
        $display("FAIL R9: got flags %b%b/%b%b exp 00/00", sec_s, ded_s, sec_h, ded_h);
      end
    end
  endtask

  task automatic step(input bit v, input logic [DW-1:0] d, input bit en, input logic [1:0] k,
                      input int a, input int b, input int tag_over);
    logic [DW-1:0] ed;
    bit es, ee;
    int tg;
    @(negedge clk);
    check_out();
    for (int i = 2; i > 0; i--) begin
      hv[i] = hv[i-1]; hd_s[i] = hd_s[i-1]; hd_h[i] = hd_h[i-1];
      hsec_s[i] = hsec_s[i-1]; hded_s[i] = hded_s[i-1];
      hsec_h[i] = hsec_h[i-1]; hded_h[i] = hded_h[i-1];
      htag_s[i] = htag_s[i-1]; htag_h[i] = htag_h[i-1];
    end
    valid_in = v; data_in = d; fault_en = en; fault_kind = k;
    pos_a = PW'(a); pos_b = PW'(b);
    hv[0] = v;
    model(d, 1'b1, en, k, a, b, NS, tag_over, ed, es, ee, tg);
    hd_s[0] = ed; hsec_s[0] = es; hded_s[0] = ee; htag_s[0] = tg;
    model(d, 1'b0, en, k, a, b, NP, tag_over, ed, es, ee, tg);
    hd_h[0] = ed; hsec_h[0] = es; hded_h[0] = ee; htag_h[0] = tg;
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      hv[i] = 0; hd_s[i] = '0; hd_h[i] = '0; hsec_s[i] = 0; hded_s[i] = 0;
      hsec_h[i] = 0; hded_h[i] = 0; htag_s[i] = 1; htag_h[i] = 1;
    end
  endtask

  task automatic check_reset();
    checks++;
    if (!(vo_s === 1'b0 && sec_s === 1'b0 && ded_s === 1'b0 &&
          vo_h === 1'b0 && sec_h === 1'b0 && ded_h === 1'b0)) begin
      errors++;
      $display("FAIL R10: got v=%b%b sec=%b%b ded=%b%b exp all 0",
               vo_s, vo_h, sec_s, sec_h, ded_s, ded_h);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1: watchdog expired, got hung run exp completion");
    finish_run();
  end

  initial begin
    logic [31:0] cw;
    void'($urandom(32'h1d2c3b4a));
    clear_hist();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();                                   // R10 at start
    rst = 1'b0;

    // R2: fault stage off, assorted patterns back to back
    step(1, 8'h00, 0, 2'd0, 0, 0, 0);
    step(1, 8'hFF, 0, 2'd1, 3, 0, 0);
    step(1, 8'hA5, 0, 2'd2, 1, 2, 0);
    step(1, 8'h3C, 0, 2'd0, 5, 0, 0);
    // R3: code 3 means no fault even when enabled
    step(1, 8'h96, 1, 2'd3, 2, 7, 3);
    step(0, 8'h00, 0, 2'd3, 0, 0, 0);

    // R4: hold each index at the opposite value; R5: hold at the same value
    for (int i = 0; i < NS; i++) begin
      cw = enc(8'h5A, 1'b1);
      step(1, 8'h5A, 1, cw[i] ? 2'd0 : 2'd1, i, 0, 0);
    end
    for (int i = 0; i < NS; i++) begin
      cw = enc(8'hC3, 1'b1);
      step(1, 8'hC3, 1, cw[i] ? 2'd1 : 2'd0, i, 0, 0);
    end

    // R6 / R11: two distinct indices inverted
    for (int i = 0; i < NS; i++)
      step(1, DW'(8'h11 * i), 1, 2'd2, i, (i + 3) % NS, 0);
    step(1, 8'h7E, 1, 2'd2, 0, 12, 0);
    step(1, 8'h81, 1, 2'd2, 12, 11, 0);

    // R7: equal indices cancel
    step(1, 8'h4B, 1, 2'd2, 4, 4, 7);
    step(1, 8'hB4, 1, 2'd2, 12, 12, 7);

    // R8: indices past the codeword
    step(1, 8'h2D, 1, 2'd0, 13, 0, 8);
    step(1, 8'hD2, 1, 2'd1, 20, 0, 8);
    step(1, 8'h69, 1, 2'd2, 31, 14, 8);
    step(0, 8'h00, 0, 2'd3, 0, 0, 0);
    step(0, 8'h00, 0, 2'd3, 0, 0, 0);

    // R10: reset in the middle of a stream
    step(1, 8'hE7, 1, 2'd0, 2, 0, 0);
    step(1, 8'h18, 1, 2'd2, 1, 9, 0);
    @(negedge clk);
    rst = 1'b1;
    valid_in = 1'b1;
    @(negedge clk);
    check_reset();
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    valid_in = 1'b0;
    clear_hist();

    // Random traffic with gaps
    for (int n = 0; n < 800; n++)
      step(($urandom % 4) != 0, DW'($urandom), $urandom % 2, 2'($urandom),
           $urandom % 16, $urandom % 16, 0);
    for (int n = 0; n < 4; n++)
      step(0, 8'h00, 0, 2'd3, 0, 0, 0);

    finish_run();
  end

endmodule